// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O bank on a simple synchronous register bus. For each pin, software can set an output value and an output-drive enable, and can read the pin's level after a two-flop synchronizer. Each pin also has an interrupt detector. It can be set to edge or level mode and to either polarity. A route bit decides whether the pin feeds the sticky status register at all. Status bits that are set and also enabled are ORed into one bank interrupt line.

Every writable register has three write views. The base offset loads the whole word. Base+0x4 sets the bits written as one. Base+0x8 clears the bits written as one. Software can therefore change single pins without a read-modify-write. The status register is the exception: it changes from the bus only through its clear view, and it is set only by pin events.

A bus access is a single cycle. Writes take effect on the clock edge where `bus_wr` is high. `bus_rdata` is a combinational function of `bus_addr`.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads zero, `pin_out` and `pin_oe` are zero and `irq_o` is low.
- R2: Address bits [6:4] select the register: output value 0x00, input 0x10, drive enable 0x20, route 0x30, interrupt enable 0x40, level select 0x50, polarity 0x60, status 0x70. Address bits [3:2] select the view: 0 loads the word, 1 ORs in the written ones, 2 clears the written ones. Accesses with bit 7 or bits [1:0] nonzero neither write nor read (reads return zero).
- R3: A read at any view (+0x0, +0x4, +0x8, +0xC) of a register returns its base value. A write to the +0xC view changes nothing.
- R4: `pin_out` always equals the output value register. `pin_oe` equals the drive-enable register, where 1 means the pin is driven.
- R5: The input register returns `pin_in` after two clock edges of synchronization: a change is invisible after one edge and visible after two. Writes to the input register are ignored.
- R6: With level-select 0 (edge mode), polarity 1 captures a rising edge and polarity 0 captures a falling edge of the synchronized pin into its status bit. The bit stays set after the pin returns.
- R7: With level-select 1 (level mode), the status bit sets while the synchronized pin equals its polarity bit. If that level is still present, a clear does not leave the bit at zero.
- R8: A pin whose route bit is 0 never sets its status bit.
- R9: A write of ones to the status clear view (0x78) clears those bits. Writes to 0x70 and 0x74 leave status unchanged. A clear does not change any configuration register. A detection in the same cycle as its clear wins.
- R10: `irq_o` is high exactly when some status bit and its interrupt enable bit are both one. The enable does not gate status capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address within the bank window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output value to the pads |
| pin_oe | output | 32 | Drive enable to the pads, 1 drives |
| irq_o | output | 1 | Bank interrupt |

## Verification
The bench aims at the alias views. A design that decodes the set or clear view as a plain load would wipe neighbouring bits, and one that decodes reads by view would return junk at +0x4/+0x8. It checks that status survives plain and set writes and that edge mode ignores the opposite edge and holds the bit after the pin returns. It checks that a level-mode pin whose level persists refuses to stay cleared. This catches a design that lets a clear beat a same-cycle event. It also times the input read to the second edge, which catches a synchronizer one stage short, and checks that unrouted pins and disabled enables behave as specified.

// File: rtl/gpio_bank_pkg.sv
// Shared decode types for the GPIO bank.
package gpio_bank_pkg;

    // Register selected by address bits [6:4]; the order fixes the address map.
    typedef enum logic [2:0] {
        REG_OUTVAL = 3'd0,
        REG_INVAL  = 3'd1,
        REG_DRIVE  = 3'd2,
        REG_ROUTE  = 3'd3,
        REG_ENABLE = 3'd4,
        REG_LEVEL  = 3'd5,
        REG_POLAR  = 3'd6,
        REG_STATUS = 3'd7
    } reg_sel_e;

    // Write view selected by address bits [3:2].
    typedef enum logic [1:0] {
        ACC_LOAD = 2'd0,
        ACC_SET  = 2'd1,
        ACC_CLR  = 2'd2,
        ACC_NONE = 2'd3
    } acc_e;

endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for asynchronous pin levels.
// Assumes each bit is independent (no bus coherency is required).
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] stage_q;

    // Shift the pin levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_alias_reg.sv
// Configuration register with load, set-bits and clear-bits write views.
// Assumes at most one of the three strobes is high in a cycle.
module gpio_alias_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_load,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Apply the selected write view; reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_load) begin
            q <= wdata;
        end else if (wr_set) begin
            q <= q | wdata;
        end else if (wr_clr) begin
            q <= q & ~wdata;
        end
    end
endmodule

// File: rtl/gpio_irq_detect.sv
// Per-pin interrupt detection and sticky status.
// Assumes sync_in is already synchronous to clk. An event in the same
// cycle as a clear of its bit keeps the bit set.
module gpio_irq_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_in,
    input  logic [W-1:0] route,
    input  logic [W-1:0] level,
    input  logic [W-1:0] polarity,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] event_o,
    output logic [W-1:0] status
);
    logic [W-1:0] prev_q;

    // Hold the previous synchronized sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_in;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise, fall, lvl_hit, edge_hit;
        // Classify this pin's current sample against its configuration.
        always_comb begin
            rise     = sync_in[i] & ~prev_q[i];
            fall     = ~sync_in[i] & prev_q[i];
            edge_hit = polarity[i] ? rise : fall;
            lvl_hit  = (sync_in[i] == polarity[i]);
            event_o[i] = route[i] & (level[i] ? lvl_hit : edge_hit);
        end
    end

    // Sticky status: clear by mask, events take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | event_o;
    end
endmodule

// File: rtl/gpio_irq_bank.sv
// GPIO bank top: register decode, alias views, read mux, pad outputs
// and interrupt combine. Assumes a single-cycle bus with combinational read.
module gpio_irq_bank #(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 8,
    parameter int SYNC_STG = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq_o
);
    import gpio_bank_pkg::*;

    localparam int ACC_LSB  = 2;
    localparam int SEL_LSB  = 4;
    localparam int SEL_W    = 3;
    localparam int NUM_REGS = 1 << SEL_W;
    localparam int TOP_LSB  = SEL_LSB + SEL_W;

    reg_sel_e                     sel;
    acc_e                         acc;
    logic                         in_window;
    logic [NUM_REGS-1:0]          wr_hit;
    logic [NUM_REGS-1:0][NUM_PINS-1:0] reg_q;
    logic [NUM_PINS-1:0]          din_sync, stat_q, evt, clr_mask;
    logic [NUM_PINS-1:0]          route_q, ien_q, lvl_q, pol_q;

    // Decode the address into register, view and window hit.
    always_comb begin
        sel       = reg_sel_e'(bus_addr[SEL_LSB +: SEL_W]);
        acc       = acc_e'(bus_addr[ACC_LSB +: 2]);
        in_window = (bus_addr[ADDR_W-1:TOP_LSB] == '0) && (bus_addr[1:0] == 2'b00);
        for (int r = 0; r < NUM_REGS; r++) begin
            wr_hit[r] = bus_wr && in_window && (sel == reg_sel_e'(r));
        end
    end

    gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STG)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(din_sync)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (g == int'(REG_INVAL)) begin : g_in
            assign reg_q[g] = din_sync;
        end else if (g == int'(REG_STATUS)) begin : g_st
            assign reg_q[g] = stat_q;
        end else begin : g_cfg
            gpio_alias_reg #(.W(NUM_PINS)) reg_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_load(wr_hit[g] && acc == ACC_LOAD),
                .wr_set (wr_hit[g] && acc == ACC_SET),
                .wr_clr (wr_hit[g] && acc == ACC_CLR),
                .wdata  (bus_wdata),
                .q      (reg_q[g])
            );
        end
    end

    assign route_q = reg_q[REG_ROUTE];
    assign ien_q   = reg_q[REG_ENABLE];
    assign lvl_q   = reg_q[REG_LEVEL];
    assign pol_q   = reg_q[REG_POLAR];

    // Only the clear view touches status from the bus.
    assign clr_mask = (wr_hit[REG_STATUS] && acc == ACC_CLR) ? bus_wdata : '0;

    gpio_irq_detect #(.W(NUM_PINS)) det_i (
        .clk(clk), .rst_n(rst_n), .sync_in(din_sync), .route(route_q),
        .level(lvl_q), .polarity(pol_q), .clr_mask(clr_mask),
        .event_o(evt), .status(stat_q)
    );

    // Read mux: every view returns the base register.
    assign bus_rdata = in_window ? reg_q[sel] : '0;

    assign pin_out = reg_q[REG_OUTVAL];
    assign pin_oe  = reg_q[REG_DRIVE];
    assign irq_o   = |(stat_q & ien_q);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
// Assertion checker for the GPIO bank, attached by bind.
module gpio_irq_bank_chk #(
    parameter int N  = 32,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic [N-1:0]  bus_wdata,
    input logic [N-1:0]  pin_out,
    input logic [N-1:0]  pin_oe,
    input logic          irq_o,
    input logic [N-1:0]  status,
    input logic [N-1:0]  enable,
    input logic [N-1:0]  route,
    input logic [N-1:0]  evt
);
    localparam logic [AW-1:0] A_OUT_LOAD  = AW'(8'h00);
    localparam logic [AW-1:0] A_DRV_SET   = AW'(8'h24);
    localparam logic [AW-1:0] A_STAT_CLR  = AW'(8'h78);

    logic stat_clr_wr;
    assign stat_clr_wr = bus_wr && (bus_addr == A_STAT_CLR);

    // R4
    out_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_OUT_LOAD) |=> (pin_out == $past(bus_wdata)));

    // R2
    drv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DRV_SET) |=> (pin_oe == ($past(pin_oe) | $past(bus_wdata))));

    // R8
    no_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route == '0 && status == '0) |=> (status == '0));

    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_clr_wr |=> (($past(status) & ~status) == '0));

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr_wr |=> ((status & $past(bus_wdata) & ~$past(evt)) == '0));

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq_o);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.N(NUM_PINS), .AW(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o),
    .status(stat_q), .enable(ien_q), .route(route_q), .evt(evt)
);

// File: tb/gpio_irq_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq_o;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    gpio_irq_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic [7:0]  wa;
        logic [31:0] wd;
        logic [7:0]  ra;
        logic [31:0] ex;
    } vec_t;

    // Write then read-back vectors; pins held low throughout.
    localparam vec_t VECS [10] = '{
        '{8'h00, 32'hA5A5_0000, 8'h00, 32'hA5A5_0000},  // R2 load
        '{8'h04, 32'h0000_00FF, 8'h00, 32'hA5A5_00FF},  // R2 set view
        '{8'h08, 32'hA000_000F, 8'h04, 32'h05A5_00F0},  // R2 clear, R3 read at +4
        '{8'h20, 32'hFFFF_0000, 8'h28, 32'hFFFF_0000},  // R3 read at +8
        '{8'h28, 32'h0F0F_0000, 8'h20, 32'hF0F0_0000},  // R2 clear view
        '{8'h0C, 32'h1234_5678, 8'h00, 32'h05A5_00F0},  // R3 +0xC ignored
        '{8'h10, 32'hFFFF_FFFF, 8'h10, 32'h0000_0000},  // R5 input write ignored
        '{8'h50, 32'h0000_FFFF, 8'h5C, 32'h0000_FFFF},  // R3 read at +0xC
        '{8'h60, 32'h1234_5678, 8'h68, 32'h1234_5678},  // R2 polarity
        '{8'h81, 32'hFFFF_FFFF, 8'h00, 32'h05A5_00F0}   // R2 out-of-window ignored
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        cycles(2);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        do_reset();

        // Table walk.
        for (int i = 0; i < 10; i++) begin
            bus_write(VECS[i].wa, VECS[i].wd);
            bus_read(VECS[i].ra, rd);
            check($sformatf("R2 R3 R5 vector %0d", i), rd, VECS[i].ex);
        end
        check("R4 pin_out", pin_out, 32'h05A5_00F0);
        check("R4 pin_oe", pin_oe, 32'hF0F0_0000);

        // R1 reset state.
        do_reset();
        for (int a = 0; a < 8; a++) begin
            bus_read(8'(a * 16), rd);
            check($sformatf("R1 reg 0x%0h", a * 16), rd, 32'h0);
        end
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 irq_o", {31'h0, irq_o}, 32'h0);

        // R8 unrouted rising edge on pin 0.
        bus_write(8'h60, 32'h0000_0005);  // pol pins 0,2 high
        @(negedge clk); pin_in[0] = 1'b1;
        cycles(4);
        bus_read(8'h70, rd);
        check("R8 unrouted", rd, 32'h0);

        // R6 rising edge with route set.
        @(negedge clk); pin_in[0] = 1'b0;
        bus_write(8'h34, 32'h0000_0003);
        cycles(4);
        bus_read(8'h70, rd);
        check("R6 no event on fall with pol1", rd, 32'h0);
        @(negedge clk); pin_in[0] = 1'b1;
        cycles(4);
        bus_read(8'h70, rd);
        check("R6 rising captured", rd, 32'h1);
        check("R10 irq low while disabled", {31'h0, irq_o}, 32'h0);
        bus_write(8'h44, 32'h0000_0001);
        #1 check("R10 irq high when enabled", {31'h0, irq_o}, 32'h1);
        @(negedge clk); pin_in[0] = 1'b0;
        cycles(4);
        bus_read(8'h70, rd);
        check("R6 sticky after pin return", rd, 32'h1);

        // R9 plain and set writes do not touch status.
        bus_write(8'h70, 32'h0);
        bus_write(8'h74, 32'hFFFF_FFFF);
        bus_read(8'h70, rd);
        check("R9 plain/set ignored", rd, 32'h1);
        bus_write(8'h78, 32'h0000_0001);
        bus_read(8'h70, rd);
        check("R9 cleared", rd, 32'h0);
        check("R10 irq low after clear", {31'h0, irq_o}, 32'h0);
        bus_read(8'h30, rd);
        check("R9 route kept", rd, 32'h3);
        bus_read(8'h40, rd);
        check("R9 enable kept", rd, 32'h1);

        // R6 falling edge on pin 1 (pol 0).
        @(negedge clk); pin_in[1] = 1'b1;
        cycles(4);
        bus_read(8'h70, rd);
        check("R6 rise ignored with pol0", rd, 32'h0);
        @(negedge clk); pin_in[1] = 1'b0;
        cycles(4);
        bus_read(8'h70, rd);
        check("R6 falling captured", rd, 32'h2);
        bus_write(8'h78, 32'h0000_0002);

        // R7 level-high on pin 2.
        bus_write(8'h50, 32'h0000_000C);
        bus_write(8'h34, 32'h0000_0004);
        @(negedge clk); pin_in[2] = 1'b1;
        cycles(4);
        bus_read(8'h70, rd);
        check("R7 level high sets", rd, 32'h4);
        bus_write(8'h78, 32'h0000_0004);
        bus_read(8'h70, rd);
        check("R7 clear loses to held level", rd, 32'h4);
        @(negedge clk); pin_in[2] = 1'b0;
        cycles(4);
        bus_write(8'h78, 32'h0000_0004);
        bus_read(8'h70, rd);
        check("R7 clear after level gone", rd, 32'h0);

        // R7 level-low on pin 3 (pol 0, pin low) sets once routed.
        bus_write(8'h34, 32'h0000_0008);
        cycles(1);
        bus_read(8'h70, rd);
        check("R7 level low sets", rd, 32'h8);

        // R5 synchronizer latency.
        bus_read(8'h10, rd);
        check("R5 input low before change", rd, 32'h0);
        @(negedge clk); pin_in[31:16] = 16'hBEEF;
        @(negedge clk);
        #1 check("R5 not visible after one edge", bus_rdata, 32'h0);
        @(negedge clk);
        #1 check("R5 visible after two edges", bus_rdata, 32'hBEEF_0000);

        finish_run();
    end
endmodule